// File: doc/BRIEF.md
# Privileged Special Register File

This block keeps the small set of special registers a CPU core needs for trap handling and supervision: a status word carrying condition flags, a current privilege level and a prior privilege level, a saved trap program counter, a saved faulting address, a scratch word reserved for trap software, and a counter that advances once per memory reference. The core issues get and set requests by register index. A set takes either the supplied write data or, when the operand is the zero register, the constant zero. A get returns the selected register one cycle later.

When a trap occurs, the block saves the current PC, saves the faulting address if the trap came from addressing, moves the current level into the prior-level field and drops to the most privileged level. A get whose destination is the zero register asks the core to load the returned value as the new PC and restores the prior level, so a get of the saved trap PC in that form is the return-from-trap. While the current level is all ones, every get and set is refused and a privilege-violation pulse is raised instead.

Top module: `priv_sreg_file`

## Requirements
- R1: After reset every special register reads zero, the current and prior levels are 0, and rd_data, pc_load and priv_trap are all 0.
- R2: Register index 0 is the status word (flags in bits 3:0, prior level in bits 11:8, current level in bits 15:12, all other bits read 0), 1 the trap PC, 2 the fault address, 3 the scratch word and 8 the memory-reference counter; req_kind encodes 0 idle, 1 get, 2 set, 3 idle; a get returns the register's value on rd_data in the cycle after the request, and rd_data is 0 in every cycle that does not follow an executed get.
- R3: A set with req_reg_zero high writes 0 into the selected register whatever req_wdata holds.
- R4: A get or set issued while the current level is 4'b1111 does not execute: priv_trap is 1 in the next cycle, rd_data and pc_load stay 0 and no register changes.
- R5: A get with req_reg_zero high raises pc_load in the next cycle with rd_data holding the read value, and copies the prior level into the current level; a get without it leaves pc_load 0 and the levels unchanged.
- R6: On trap_event the trap PC takes cur_pc, the prior level takes the current level and the current level becomes 0; a get or set in the same cycle is dropped.
- R7: The fault address register takes trap_addr only on a trap_event with trap_is_addr high; other traps leave it unchanged.
- R8: The counter increments by one (wrapping) on each cycle with memref_strobe high; a set of index 8 in the same cycle takes precedence, and a get in the same cycle returns the value before the increment.
- R9: The flags change only through a set of index 0; gets, traps and return-from-trap leave them unchanged.
- R10: Gets of indices 4 to 7 and 9 to 15 return 0 and sets of them change no register.
- R11: The scratch word holds the last value written to it and is unaffected by traps and memory references.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_kind | input | 2 | Request type: 0 idle, 1 get, 2 set, 3 idle |
| req_idx | input | IDX_W | Special register index |
| req_wdata | input | DATA_W | Data for a set |
| req_reg_zero | input | 1 | Operand register is the zero register (set: write zero; get: load PC and return) |
| trap_event | input | 1 | A trap is taken this cycle |
| trap_is_addr | input | 1 | The trap was caused by memory addressing |
| cur_pc | input | DATA_W | PC to save on a trap |
| trap_addr | input | DATA_W | Faulting virtual address for an addressing trap |
| memref_strobe | input | 1 | One memory reference (fetch, load or store) this cycle |
| rd_data | output | DATA_W | Value returned by a get, one cycle after the request |
| pc_load | output | 1 | Core must load rd_data as its new PC |
| priv_trap | output | 1 | Privilege violation for the request of the previous cycle |

## Verification
The bench targets the interactions that a careless design gets wrong: a set colliding with a trap, which would corrupt the scratch word if the request were not dropped; a get through the zero register, which without the level restore would leave the core at the trap level after returning; and a locked level, where a design that checked privilege after decoding would still write the register or return data. It also drives a counter set and a memory reference in the same cycle and a counter at all ones, where a wrong priority or width would show a value off by one, and reads unimplemented indices, where an incomplete decode would alias onto a real register.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   typedef enum logic [1:0] {
      REQ_IDLE = 2'd0,
      REQ_GET  = 2'd1,
      REQ_SET  = 2'd2,
      REQ_RSVD = 2'd3
   } req_kind_e;

   localparam int unsigned LVL_W      = 4;
   localparam int unsigned FLAG_W     = 4;
   localparam int unsigned FLAG_LSB   = 0;
   localparam int unsigned PRIOR_LSB  = 8;
   localparam int unsigned CUR_LSB    = 12;
   localparam int unsigned STATUS_MSB = CUR_LSB + LVL_W - 1;

   localparam int unsigned IDX_STATUS  = 0;
   localparam int unsigned IDX_TRAP_PC = 1;
   localparam int unsigned IDX_FAULT   = 2;
   localparam int unsigned IDX_SCRATCH = 3;
   localparam int unsigned IDX_COUNT   = 8;

   localparam logic [LVL_W-1:0] LVL_LOCKED = '1;
   localparam logic [LVL_W-1:0] LVL_TOP    = '0;

endpackage

// File: rtl/sreg_status.sv
module sreg_status
   import sreg_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_val,
   input  logic              restore,
   input  logic              trap_take,
   output logic [LVL_W-1:0]  cur_level,
   output logic [LVL_W-1:0]  prior_level,
   output logic [FLAG_W-1:0] flags,
   output logic [DATA_W-1:0] word
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_level   <= LVL_TOP;
         prior_level <= LVL_TOP;
         flags       <= '0;
      end else if (trap_take) begin
         prior_level <= cur_level;
         cur_level   <= LVL_TOP;
      end else if (wr_en) begin
         cur_level   <= wr_val[CUR_LSB +: LVL_W];
         prior_level <= wr_val[PRIOR_LSB +: LVL_W];
         flags       <= wr_val[FLAG_LSB +: FLAG_W];
      end else if (restore) begin
         cur_level   <= prior_level;
      end
   end

   always_comb begin
      word                        = '0;
      word[FLAG_LSB +: FLAG_W]    = flags;
      word[PRIOR_LSB +: LVL_W]    = prior_level;
      word[CUR_LSB +: LVL_W]      = cur_level;
   end

endmodule

// File: rtl/sreg_trap_capture.sv
module sreg_trap_capture #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_take,
   input  logic              trap_is_addr,
   input  logic [DATA_W-1:0] cur_pc,
   input  logic [DATA_W-1:0] trap_addr,
   input  logic              wr_pc_en,
   input  logic              wr_fault_en,
   input  logic [DATA_W-1:0] wr_val,
   output logic [DATA_W-1:0] trap_pc,
   output logic [DATA_W-1:0] fault_addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_pc <= '0;
      end else if (trap_take) begin
         trap_pc <= cur_pc;
      end else if (wr_pc_en) begin
         trap_pc <= wr_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_addr <= '0;
      end else if (trap_take) begin
         if (trap_is_addr) fault_addr <= trap_addr;
      end else if (wr_fault_en) begin
         fault_addr <= wr_val;
      end
   end

endmodule

// File: rtl/sreg_counter.sv
module sreg_counter #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned COUNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_val,
   input  logic              tick,
   output logic [DATA_W-1:0] value
);

   logic [COUNT_W-1:0] cnt_q;
   logic [COUNT_W-1:0] cnt_load;

   generate
      if (COUNT_W == DATA_W) begin : g_full
         assign cnt_load = wr_val;
         assign value    = cnt_q;
      end else begin : g_narrow
         assign cnt_load = wr_val[COUNT_W-1:0];
         assign value    = {{(DATA_W-COUNT_W){1'b0}}, cnt_q};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_en) begin
         cnt_q <= cnt_load;
      end else if (tick) begin
         cnt_q <= cnt_q + COUNT_W'(1);
      end
   end

endmodule

// File: rtl/priv_sreg_file.sv
module priv_sreg_file
   import sreg_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned COUNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        req_kind,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_reg_zero,
   input  logic              trap_event,
   input  logic              trap_is_addr,
   input  logic [DATA_W-1:0] cur_pc,
   input  logic [DATA_W-1:0] trap_addr,
   input  logic              memref_strobe,
   output logic [DATA_W-1:0] rd_data,
   output logic              pc_load,
   output logic              priv_trap
);

   localparam int unsigned NUM_IDX = 1 << IDX_W;

   generate
      if (DATA_W <= STATUS_MSB) begin : g_bad_data_w
         $error("priv_sreg_file: DATA_W too small for the status word");
      end
      if (IDX_W < 4) begin : g_bad_idx_w
         $error("priv_sreg_file: IDX_W must reach index 8");
      end
      if (COUNT_W == 0 || COUNT_W > DATA_W) begin : g_bad_count_w
         $error("priv_sreg_file: COUNT_W must be 1..DATA_W");
      end
   endgenerate

   logic [LVL_W-1:0]  cur_level;
   logic [LVL_W-1:0]  prior_level;
   logic [FLAG_W-1:0] flags;
   logic [DATA_W-1:0] status_word;
   logic [DATA_W-1:0] trap_pc_q;
   logic [DATA_W-1:0] fault_q;
   logic [DATA_W-1:0] scratch_q;
   logic [DATA_W-1:0] count_val;

   logic              is_access;
   logic              locked;
   logic              exec_get;
   logic              exec_set;
   logic [DATA_W-1:0] set_val;
   logic [NUM_IDX-1:0] idx_hit;
   logic [DATA_W-1:0] rd_mux;

   assign is_access = (req_kind == REQ_GET || req_kind == REQ_SET) && !trap_event;
   assign locked    = (cur_level == LVL_LOCKED);
   assign exec_get  = is_access && !locked && (req_kind == REQ_GET);
   assign exec_set  = is_access && !locked && (req_kind == REQ_SET);
   assign set_val   = req_reg_zero ? '0 : req_wdata;

   generate
      for (genvar i = 0; i < NUM_IDX; i++) begin : g_dec
         assign idx_hit[i] = (req_idx == IDX_W'(i));
      end
   endgenerate

   sreg_status #(.DATA_W(DATA_W)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (exec_set && idx_hit[IDX_STATUS]),
      .wr_val      (set_val),
      .restore     (exec_get && req_reg_zero),
      .trap_take   (trap_event),
      .cur_level   (cur_level),
      .prior_level (prior_level),
      .flags       (flags),
      .word        (status_word)
   );

   sreg_trap_capture #(.DATA_W(DATA_W)) u_trap (
      .clk          (clk),
      .rst_n        (rst_n),
      .trap_take    (trap_event),
      .trap_is_addr (trap_is_addr),
      .cur_pc       (cur_pc),
      .trap_addr    (trap_addr),
      .wr_pc_en     (exec_set && idx_hit[IDX_TRAP_PC]),
      .wr_fault_en  (exec_set && idx_hit[IDX_FAULT]),
      .wr_val       (set_val),
      .trap_pc      (trap_pc_q),
      .fault_addr   (fault_q)
   );

   sreg_counter #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (exec_set && idx_hit[IDX_COUNT]),
      .wr_val (set_val),
      .tick   (memref_strobe),
      .value  (count_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scratch_q <= '0;
      end else if (exec_set && idx_hit[IDX_SCRATCH]) begin
         scratch_q <= set_val;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (idx_hit[IDX_STATUS])  rd_mux = status_word;
      if (idx_hit[IDX_TRAP_PC]) rd_mux = trap_pc_q;
      if (idx_hit[IDX_FAULT])   rd_mux = fault_q;
      if (idx_hit[IDX_SCRATCH]) rd_mux = scratch_q;
      if (idx_hit[IDX_COUNT])   rd_mux = count_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data   <= '0;
         pc_load   <= 1'b0;
         priv_trap <= 1'b0;
      end else begin
         rd_data   <= exec_get ? rd_mux : '0;
         pc_load   <= exec_get && req_reg_zero;
         priv_trap <= is_access && locked;
      end
   end

endmodule

// File: rtl/priv_sreg_file_chk.sv
module priv_sreg_file_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        req_kind,
   input logic [IDX_W-1:0]  req_idx,
   input logic              req_reg_zero,
   input logic              trap_event,
   input logic              memref_strobe,
   input logic [DATA_W-1:0] cur_pc,
   input logic [DATA_W-1:0] rd_data,
   input logic              pc_load,
   input logic              priv_trap,
   input logic [3:0]        cur_level,
   input logic [3:0]        prior_level,
   input logic [3:0]        flags,
   input logic [DATA_W-1:0] trap_pc_q,
   input logic [DATA_W-1:0] count_val
);

   logic req_any;
   logic ok;
   logic set_count;
   logic set_status;

   assign req_any    = (req_kind == 2'd1 || req_kind == 2'd2) && !trap_event;
   assign ok         = (cur_level != 4'hF);
   assign set_count  = req_any && ok && req_kind == 2'd2 && req_idx == IDX_W'(8);
   assign set_status = req_any && ok && req_kind == 2'd2 && req_idx == IDX_W'(0);

   // R4: a locked level turns the request into a privilege trap with no data
   assert_priv_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_any && !ok) |=> (priv_trap && !pc_load && rd_data == '0));

   // R5: zero-destination get loads the PC and restores the prior level
   assert_return_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_any && ok && req_kind == 2'd1 && req_reg_zero)
      |=> (pc_load && cur_level == $past(prior_level)));

   // R6: a trap saves the PC and shifts the levels
   assert_trap_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_event |=> (cur_level == 4'h0 && prior_level == $past(cur_level)
                      && trap_pc_q == $past(cur_pc)));

   // R8: one increment per memory reference unless a set wins
   assert_count_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (memref_strobe && !set_count) |=> count_val == $past(count_val) + DATA_W'(1));

   // R8: no reference and no set keeps the counter
   assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!memref_strobe && !set_count) |=> $stable(count_val));

   // R9: flags move only through a set of the status word
   assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !set_status |=> $stable(flags));

   // R4 R5: a PC load and a privilege trap never coincide
   assert_out_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pc_load, priv_trap}));

endmodule

bind priv_sreg_file priv_sreg_file_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_kind      (req_kind),
   .req_idx       (req_idx),
   .req_reg_zero  (req_reg_zero),
   .trap_event    (trap_event),
   .memref_strobe (memref_strobe),
   .cur_pc        (cur_pc),
   .rd_data       (rd_data),
   .pc_load       (pc_load),
   .priv_trap     (priv_trap),
   .cur_level     (cur_level),
   .prior_level   (prior_level),
   .flags         (flags),
   .trap_pc_q     (trap_pc_q),
   .count_val     (count_val)
);

// File: tb/priv_sreg_file_tb.sv
module priv_sreg_file_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    req_kind = 2'd0;
   logic [3:0]    req_idx = 4'd0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_reg_zero = 1'b0;
   logic          trap_event = 1'b0;
   logic          trap_is_addr = 1'b0;
   logic [DW-1:0] cur_pc = '0;
   logic [DW-1:0] trap_addr = '0;
   logic          memref_strobe = 1'b0;
   logic [DW-1:0] rd_data;
   logic          pc_load;
   logic          priv_trap;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   priv_sreg_file #(.DATA_W(DW), .IDX_W(4), .COUNT_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_idx(req_idx),
      .req_wdata(req_wdata), .req_reg_zero(req_reg_zero), .trap_event(trap_event),
      .trap_is_addr(trap_is_addr), .cur_pc(cur_pc), .trap_addr(trap_addr),
      .memref_strobe(memref_strobe), .rd_data(rd_data), .pc_load(pc_load),
      .priv_trap(priv_trap)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DW-1:0] st(input logic [3:0] cur, input logic [3:0] pri,
                                        input logic [3:0] fl);
      st = {16'h0, cur, pri, 4'h0, fl};
   endfunction

   task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic cyc(input logic [1:0] k, input logic [3:0] i, input logic [DW-1:0] d,
                      input logic z, input logic tr, input logic ta,
                      input logic [DW-1:0] pc, input logic [DW-1:0] fa, input logic ms);
      @(negedge clk);
      req_kind = k; req_idx = i; req_wdata = d; req_reg_zero = z;
      trap_event = tr; trap_is_addr = ta; cur_pc = pc; trap_addr = fa;
      memref_strobe = ms;
      @(posedge clk);
      #1;
      req_kind = 2'd0; req_reg_zero = 1'b0; trap_event = 1'b0;
      trap_is_addr = 1'b0; memref_strobe = 1'b0;
   endtask

   task automatic set_reg(input logic [3:0] i, input logic [DW-1:0] d);
      cyc(2'd2, i, d, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
   endtask

   task automatic get_reg(input logic [3:0] i, output logic [DW-1:0] v);
      cyc(2'd1, i, '0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
      v = rd_data;
   endtask

   task automatic test_reset();
      logic [DW-1:0] v;
      check("R1 rd_data", rd_data, '0);
      check("R1 pc_load", {31'b0, pc_load}, 0);
      check("R1 priv_trap", {31'b0, priv_trap}, 0);
      foreach (v[b]) begin end
      for (int i = 0; i < 16; i++) begin
         get_reg(4'(i), v);
         check("R1 register zero", v, '0);
      end
   endtask

   task automatic test_map();
      logic [DW-1:0] v;
      set_reg(4'd3, 32'hDEADBEEF);
      set_reg(4'd2, 32'h11110000);
      set_reg(4'd1, 32'h00002222);
      set_reg(4'd0, 32'hFFFF3A5C);
      get_reg(4'd3, v); check("R2 scratch", v, 32'hDEADBEEF);
      get_reg(4'd2, v); check("R2 fault addr", v, 32'h11110000);
      get_reg(4'd1, v); check("R2 trap pc", v, 32'h00002222);
      get_reg(4'd0, v); check("R2 status fields", v, st(4'h3, 4'hA, 4'hC));
      check("R5 plain get no pc_load", {31'b0, pc_load}, 0);
      cyc(2'd0, 4'd3, '0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
      check("R2 rd_data idle zero", rd_data, '0);
   endtask

   task automatic test_zero_write();
      logic [DW-1:0] v;
      cyc(2'd2, 4'd3, 32'h12345678, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0);
      get_reg(4'd3, v); check("R3 zero operand set", v, '0);
   endtask

   task automatic test_unimpl();
      logic [DW-1:0] v;
      set_reg(4'd3, 32'h00000055);
      set_reg(4'd5, 32'hAAAAAAAA);
      set_reg(4'd12, 32'hBBBBBBBB);
      get_reg(4'd5, v);  check("R10 idx5 reads zero", v, '0);
      get_reg(4'd12, v); check("R10 idx12 reads zero", v, '0);
      get_reg(4'd3, v);  check("R10 scratch untouched", v, 32'h55);
      get_reg(4'd1, v);  check("R10 trap pc untouched", v, 32'h2222);
      get_reg(4'd0, v);  check("R10 R9 status untouched", v, st(4'h3, 4'hA, 4'hC));
   endtask

   task automatic test_trap();
      logic [DW-1:0] v;
      cyc(2'd2, 4'd3, 32'h99, 1'b0, 1'b1, 1'b1, 32'h40000100, 32'hBAD00004, 1'b0);
      get_reg(4'd0, v); check("R6 R9 status after trap", v, st(4'h0, 4'h3, 4'hC));
      get_reg(4'd1, v); check("R6 trap pc saved", v, 32'h40000100);
      get_reg(4'd2, v); check("R7 fault saved", v, 32'hBAD00004);
      get_reg(4'd3, v); check("R6 R11 set dropped on trap", v, 32'h55);
      cyc(2'd0, 4'd0, '0, 1'b0, 1'b1, 1'b0, 32'h00000500, 32'h00000001, 1'b0);
      get_reg(4'd2, v); check("R7 non-address trap keeps fault", v, 32'hBAD00004);
      get_reg(4'd1, v); check("R6 second trap pc", v, 32'h500);
      get_reg(4'd0, v); check("R6 levels after second trap", v, st(4'h0, 4'h0, 4'hC));
   endtask

   task automatic test_return();
      logic [DW-1:0] v;
      set_reg(4'd0, st(4'h0, 4'h6, 4'hC));
      cyc(2'd1, 4'd1, '0, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0);
      check("R5 pc_load", {31'b0, pc_load}, 1);
      check("R5 return pc", rd_data, 32'h500);
      get_reg(4'd0, v); check("R5 R9 level restored", v, st(4'h6, 4'h6, 4'hC));
      check("R5 pc_load drops", {31'b0, pc_load}, 0);
   endtask

   task automatic test_priv();
      logic [DW-1:0] v;
      set_reg(4'd0, st(4'hF, 4'h2, 4'hC));
      get_reg(4'd0, v);
      check("R4 get refused data", v, '0);
      check("R4 priv_trap on get", {31'b0, priv_trap}, 1);
      cyc(2'd2, 4'd3, 32'h77, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
      check("R4 priv_trap on set", {31'b0, priv_trap}, 1);
      cyc(2'd1, 4'd1, '0, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0);
      check("R4 no pc_load when locked", {31'b0, pc_load}, 0);
      cyc(2'd0, 4'd0, '0, 1'b0, 1'b1, 1'b0, 32'h600, '0, 1'b0);
      check("R4 priv_trap clears", {31'b0, priv_trap}, 0);
      get_reg(4'd3, v); check("R4 R11 scratch kept", v, 32'h55);
      get_reg(4'd0, v); check("R4 levels after trap", v, st(4'h0, 4'hF, 4'hC));
   endtask

   task automatic test_counter();
      logic [DW-1:0] v;
      set_reg(4'd8, '0);
      for (int i = 0; i < 3; i++) cyc(2'd0, 4'd0, '0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
      get_reg(4'd8, v); check("R8 three references", v, 32'd3);
      cyc(2'd1, 4'd8, '0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
      check("R8 get sees old count", rd_data, 32'd3);
      get_reg(4'd8, v); check("R8 count after get tick", v, 32'd4);
      cyc(2'd2, 4'd8, 32'd100, 1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
      get_reg(4'd8, v); check("R8 set beats tick", v, 32'd100);
      set_reg(4'd8, 32'hFFFFFFFF);
      cyc(2'd0, 4'd0, '0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
      get_reg(4'd8, v); check("R8 wrap", v, '0);
      get_reg(4'd3, v); check("R11 scratch vs references", v, 32'h55);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      test_reset();
      test_map();
      test_zero_write();
      test_unimpl();
      test_trap();
      test_return();
      test_priv();
      test_counter();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule